// File: doc/BRIEF.md
# Three-Stage Prescaled Interval Timer

This block is a single channel of a cascaded interval timer. A prescaler sums the tick counts that arrive with each tick pulse. Each time the sum passes a per-channel threshold, the prescaler flips a divided line. A gate forces that line low while the timers are globally switched off. Each falling edge of the gated line advances an 8-bit interval counter. The interval counter is compared with a programmable target, and on every match it advances a 4-bit output counter.

Software sees only the output counter. It reads the counter with a one-cycle read strobe, and the read clears it. Because the counter advances on a falling edge of the *gated* line, changing the global gate flags can itself produce a count. The output counter wraps at 16.

The block does not decode bus accesses and does not generate the tick source.

Top module: `prescaled_interval_timer`

## Requirements
- R1: After a synchronous reset, `out_cnt` and `rd_data` are 0. The accumulator, the divided line, the stored gated line and the interval counter are also 0.
- R2: On each cycle with `tick_vld` high, `tick_cnt` is added to the accumulator. When the sum is at least `THRESH`, `THRESH` is subtracted, the remainder is kept, and one prescaler event occurs.
- R3: Each prescaler event inverts the divided line. Cycles with `tick_vld` low leave the line unchanged.
- R4: The gated line equals the divided line when `glb_en` is 1 and `glb_dis` is 0. Otherwise it is 0.
- R5: The interval counter advances only when the gated line goes from 1 to 0, at the clock edge that follows the change. Because of this, clearing `glb_en` or setting `glb_dis` while the divided line is 1 causes an advance.
- R6: The stored gated line is updated every cycle, whatever the value of `ch_en`. A falling edge seen while `ch_en` is 0 is lost, and `out_cnt` does not change.
- R7: When the interval counter, after its increment, equals `target`, it returns to 0 and the output counter increments.
- R8: With `target` equal to 0, the 8-bit interval counter matches only after 256 falling edges.
- R9: The output counter is 4 bits wide and wraps from 15 to 0.
- R10: While `rd_stb` is high, `rd_data` shows the output counter; otherwise `rd_data` is 0. The next edge clears the counter to 0. If a match lands on that same edge, the counter becomes 1.
- R11: A rising edge of `ch_en` clears the interval counter and the output counter at the next clock edge. This takes priority over any advance or read on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_vld | input | 1 | Tick pulse qualifier |
| tick_cnt | input | 5 | Number of ticks carried by this pulse, 0 to 16 |
| glb_en | input | 1 | Global timer enable flag |
| glb_dis | input | 1 | Global timer disable flag |
| ch_en | input | 1 | Per-channel enable |
| target | input | 8 | Interval compare value |
| rd_stb | input | 1 | One-cycle read-and-clear strobe |
| out_cnt | output | 4 | Output counter |
| rd_data | output | 4 | Read data, valid while `rd_stb` is high |

## Verification
A tick pulse sampled at edge k flips the divided line at edge k. If that flip is a 1→0 edge of the gated line, or if a gate flag changes during cycle k, the interval counter and the output counter change at edge k+1. That change shows on `out_cnt` after edge k+1. `rd_data` follows `rd_stb` in the same cycle, with no register on the path.

The bench keeps a behavioural model that it steps at every rising edge. The model uses the inputs held stable since the previous falling edge. The bench compares `out_cnt` and `rd_data` a short delay after each falling edge, so these latencies line up cycle for cycle.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int unsigned TICK_W   = 5;
    localparam int unsigned MAX_TICK = 16;
    localparam int unsigned IVL_W    = 8;
    localparam int unsigned OUT_W    = 4;

    typedef logic [TICK_W-1:0] tick_t;
    typedef logic [IVL_W-1:0]  ivl_t;
    typedef logic [OUT_W-1:0]  out_t;

    typedef struct packed {
        ivl_t ivl;
        out_t out;
    } cnt_state_t;

    function automatic int unsigned acc_width(input int unsigned thresh);
        return $clog2(thresh + MAX_TICK + 1);
    endfunction
endpackage

// File: rtl/pit_prescale.sv
module pit_prescale
    import pit_pkg::*;
#(
    parameter int unsigned THRESH = 128
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick_vld,
    input  tick_t tick_cnt,
    output logic  div_line
);
    localparam int unsigned ACC_W = acc_width(THRESH);
    localparam logic [ACC_W-1:0] THR = ACC_W'(THRESH);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic             wrap;

    always_comb begin
        sum  = acc_q + ACC_W'(tick_cnt);
        wrap = tick_vld && (sum >= THR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            div_line <= 1'b0;
        end else if (tick_vld) begin
            if (wrap) begin
                acc_q    <= sum - THR;
                div_line <= ~div_line;
            end else begin
                acc_q <= sum;
            end
        end
    end

    // R2: the remainder always stays below the threshold
    a_r2_acc_below_thresh: assert property (@(posedge clk) disable iff (rst)
        acc_q < THR);

    // R3: the divided line holds on idle cycles
    a_r3_line_holds_idle: assert property (@(posedge clk) disable iff (rst)
        !tick_vld |=> $stable(div_line));
endmodule

// File: rtl/pit_edge.sv
module pit_edge (
    input  logic clk,
    input  logic rst,
    input  logic div_line,
    input  logic glb_en,
    input  logic glb_dis,
    output logic fall
);
    logic eff;
    logic line_q;

    always_comb begin
        eff  = div_line & glb_en & ~glb_dis;
        fall = line_q & ~eff;
    end

    always_ff @(posedge clk) begin
        if (rst) line_q <= 1'b0;
        else     line_q <= eff;
    end

    // R4: a closed gate never reports the line as high on the next cycle
    a_r4_gate_closed_low: assert property (@(posedge clk) disable iff (rst)
        (!glb_en || glb_dis) |=> !line_q);

    // R5: a falling edge implies the line was seen high on the previous cycle
    a_r5_fall_needs_high: assert property (@(posedge clk) disable iff (rst)
        fall |-> $past(eff));
endmodule

// File: rtl/pit_interval.sv
module pit_interval
    import pit_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fall,
    input  logic ch_en,
    input  ivl_t target,
    input  logic rd_stb,
    output out_t out_cnt,
    output out_t rd_data
);
    cnt_state_t st_q, st_n;
    logic       en_q;
    logic       en_rise;
    logic       inc;
    ivl_t       ivl_inc;

    always_comb begin
        en_rise = ch_en & ~en_q;
        ivl_inc = st_q.ivl + 1'b1;
        inc     = 1'b0;
        st_n    = st_q;
        if (en_rise) begin
            st_n = '0;
        end else begin
            if (fall && ch_en) begin
                if (ivl_inc == target) begin
                    st_n.ivl = '0;
                    inc      = 1'b1;
                end else begin
                    st_n.ivl = ivl_inc;
                end
            end
            if (rd_stb)   st_n.out = inc ? out_t'(1) : '0;
            else if (inc) st_n.out = st_q.out + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            en_q <= 1'b0;
        end else begin
            st_q <= st_n;
            en_q <= ch_en;
        end
    end

    assign out_cnt = st_q.out;
    assign rd_data = rd_stb ? st_q.out : '0;

    // R6: without an enabled edge the interval counter holds
    a_r6_hold_without_edge: assert property (@(posedge clk) disable iff (rst)
        (!(fall && ch_en) && !en_rise) |=> $stable(st_q.ivl));

    // R9: the output counter moves by at most one step unless cleared
    a_r9_step_or_wrap: assert property (@(posedge clk) disable iff (rst)
        (!rd_stb && !en_rise) |=> (st_q.out == $past(st_q.out)) ||
                                   (st_q.out == $past(st_q.out) + 1'b1));

    // R10: a read leaves at most the coincident increment
    a_r10_read_clears: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> st_q.out <= out_t'(1));

    // R11: an enable rising edge clears both counters
    a_r11_rise_clears: assert property (@(posedge clk) disable iff (rst)
        en_rise |=> (st_q.ivl == '0) && (st_q.out == '0));
endmodule

// File: rtl/prescaled_interval_timer.sv
module prescaled_interval_timer
    import pit_pkg::*;
#(
    parameter int unsigned THRESH = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_vld,
    input  logic [4:0] tick_cnt,
    input  logic       glb_en,
    input  logic       glb_dis,
    input  logic       ch_en,
    input  logic [7:0] target,
    input  logic       rd_stb,
    output logic [3:0] out_cnt,
    output logic [3:0] rd_data
);
    logic div_line;
    logic fall;

    pit_prescale #(.THRESH(THRESH)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .tick_vld (tick_vld),
        .tick_cnt (tick_cnt),
        .div_line (div_line)
    );

    pit_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .div_line (div_line),
        .glb_en   (glb_en),
        .glb_dis  (glb_dis),
        .fall     (fall)
    );

    pit_interval u_ivl (
        .clk     (clk),
        .rst     (rst),
        .fall    (fall),
        .ch_en   (ch_en),
        .target  (target),
        .rd_stb  (rd_stb),
        .out_cnt (out_cnt),
        .rd_data (rd_data)
    );
endmodule

// File: tb/sim_prescaled_interval_timer.sv
`timescale 1ns/1ps
module sim_prescaled_interval_timer;
    localparam int TH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_vld = 1'b0;
    logic [4:0] tick_cnt = '0;
    logic       glb_en = 1'b0;
    logic       glb_dis = 1'b0;
    logic       ch_en = 1'b0;
    logic [7:0] target = '0;
    logic       rd_stb = 1'b0;
    logic [3:0] out_cnt;
    logic [3:0] rd_data;

    int tests = 0;
    int fails = 0;
    string phase = "R1";

    // behavioural reference state
    int  m_acc = 0, m_ivl = 0, m_out = 0;
    bit  m_tog = 0, m_line = 0, m_enp = 0;

    always #5 clk = ~clk;

    prescaled_interval_timer #(.THRESH(TH)) u0 (
        .clk(clk), .rst(rst), .tick_vld(tick_vld), .tick_cnt(tick_cnt),
        .glb_en(glb_en), .glb_dis(glb_dis), .ch_en(ch_en), .target(target),
        .rd_stb(rd_stb), .out_cnt(out_cnt), .rd_data(rd_data)
    );

    always @(posedge clk) begin
        bit eff, fl, rise, inc;
        if (rst) begin
            m_acc = 0; m_ivl = 0; m_out = 0; m_tog = 0; m_line = 0; m_enp = 0;
        end else begin
            eff  = m_tog && glb_en && !glb_dis;
            fl   = m_line && !eff;
            rise = ch_en && !m_enp;
            inc  = 0;
            if (rise) begin
                m_ivl = 0; m_out = 0;
            end else begin
                if (fl && ch_en) begin
                    m_ivl = (m_ivl + 1) % 256;
                    if (m_ivl == int'(target)) begin m_ivl = 0; inc = 1; end
                end
                if (rd_stb)   m_out = inc ? 1 : 0;
                else if (inc) m_out = (m_out + 1) % 16;
            end
            if (tick_vld) begin
                m_acc += int'(tick_cnt);
                if (m_acc >= TH) begin m_acc -= TH; m_tog = !m_tog; end
            end
            m_line = eff;
            m_enp  = ch_en;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #2;
        if (!rst) begin
            chk(phase, int'(out_cnt), m_out);
            chk(phase, int'(rd_data), rd_stb ? m_out : 0);
        end
    end

    task automatic pulse(input int n, input int cnt);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_vld = 1'b1; tick_cnt = 5'(cnt);
        end
        @(negedge clk);
        tick_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_once();
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        chk("R1", int'(out_cnt), 0);
        chk("R1", int'(rd_data), 0);

        // R2 R3 R7: regular and uneven tick pulses
        phase = "R2"; glb_en = 1'b1; ch_en = 1'b1; target = 8'd3;
        pulse(30, 16);
        pulse(40, 5);
        phase = "R3"; pulse(25, 7); idle(4);
        phase = "R7"; target = 8'd2; pulse(40, 11);

        // R5: gate-induced falling edge
        phase = "R5";
        target = 8'd1;
        while (!m_tog) pulse(1, 16);
        idle(2);
        @(negedge clk); glb_en = 1'b0;
        idle(3);
        @(negedge clk); glb_en = 1'b1;
        idle(3);
        // R4: disable flag masks the line
        phase = "R4";
        @(negedge clk); glb_dis = 1'b1;
        pulse(20, 16);
        @(negedge clk); glb_dis = 1'b0;
        pulse(10, 16);

        // R6: edges while the channel is off are lost
        phase = "R6";
        @(negedge clk); ch_en = 1'b0;
        pulse(20, 16);
        @(negedge clk); ch_en = 1'b1;
        pulse(12, 16);

        // R10: read and clear, plus coincident increment
        phase = "R10";
        read_once();
        pulse(9, 16);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); tick_vld = 1'b1; tick_cnt = 5'd16; rd_stb = 1'b1;
            @(negedge clk); rd_stb = 1'b0;
        end
        tick_vld = 1'b0;
        idle(3);

        // R11: rising channel enable clears both counters
        phase = "R11";
        pulse(10, 16);
        @(negedge clk); ch_en = 1'b0;
        @(negedge clk); ch_en = 1'b1;
        #2;
        idle(1);
        chk("R11", int'(out_cnt), 0);

        // R9: wrap of the output counter
        phase = "R9"; target = 8'd1;
        pulse(40, 16);

        // R8: target zero needs 256 edges
        phase = "R8"; target = 8'd0;
        @(negedge clk); ch_en = 1'b0;
        @(negedge clk); ch_en = 1'b1;
        pulse(520, 16);
        idle(3);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule